// File: doc/BRIEF.md
# Per-Branch Pattern Predictor with Set-Associative Entry Table

The block predicts the direction and destination of conditional branches. Each tracked branch has its own entry that records a tag, the last taken destination, a short record of its own recent outcomes, and a private table of two-bit saturating counters. That outcome record picks one counter from the private table. A front end presents the address of a branch's final byte on the lookup port. In the same cycle it gets back a hit flag, a taken/not-taken guess and the stored destination. When the branch resolves, the back end reports the outcome and the real destination on the update port.

Because every entry keeps its own outcome record and its own counters, any pattern that repeats with a period of five or less is learned exactly. Longer patterns are learned too when every window of four consecutive outcomes is unique. An input selects when new entries are created: either the first time a branch executes, or only the first time it is taken. Storage is a set-associative table. Replacement within a set is least recently used.

Top module: `bpred_local2l`

## Requirements
- R1: After reset no entry is valid: every lookup reports lk_hit=0, lk_taken=0 and lk_target=0.
- R2: An address selects set addr[5:2] and compares tag addr[31:6]. Addresses that differ only in bits 1:0 reach the same entry. Addresses that differ in bit 6 or above never hit each other's entry.
- R3: A lookup that misses predicts not taken and returns a zero target.
- R4: With alloc_on_exec=0, a not-taken update that misses creates no entry. A taken update that misses creates one. Later not-taken updates never remove that entry.
- R5: With alloc_on_exec=1, any update that misses creates an entry, whatever its outcome, and stores up_target.
- R6: A new entry starts with an all-zero history and every counter at 1 (weakly not taken). The allocating outcome is then applied as in R7, and up_target is stored.
- R7: An update that hits first moves the counter selected by the current history one step toward the outcome, saturating at 0 and 3. It then shifts the outcome into history bit 0. A taken update also replaces the stored target. A lookup that hits predicts taken when the selected counter is 2 or 3.
- R8: Once trained, lookups made in the same cycle as the update of that branch predict every outcome correctly for the repeating patterns TTTTN, TTNN and TTTTNNNN.
- R9: Each set holds 16 entries. Allocating into a full set evicts the entry that was least recently touched, where a touch is a lookup hit, an update hit or an allocation.
- R10: A lookup in the same cycle as an update reports the state from before that update. If both touch the same set, only the update's touch counts toward recency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_on_exec | input | 1 | 1: allocate on any missed update; 0: allocate only on a taken one |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Address of the branch's last byte for lookup |
| lk_hit | output | 1 | Lookup found an entry |
| lk_taken | output | 1 | Predicted taken |
| lk_target | output | 32 | Predicted target (zero on miss) |
| up_valid | input | 1 | Update request |
| up_addr | input | 32 | Address of the resolved branch's last byte |
| up_taken | input | 1 | Resolved outcome |
| up_target | input | 32 | Resolved target |

## Verification
Lookup and update can land in the same cycle, either on the same branch or on different branches in the same set. The bench provokes the first case by issuing the lookup and the update of one branch together. The lookup must return the prediction made from the counter before it moved, and the prediction made afterwards must follow the new history. The pattern-training runs work the same way, with every iteration a combined lookup and update. For the second case, the bench fills a set, then in one cycle looks up the oldest way while updating another way of that set. It then forces an allocation and judges by which way has disappeared.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

   localparam logic [1:0] CTR_STRONG_NT = 2'd0;
   localparam logic [1:0] CTR_WEAK_NT   = 2'd1;
   localparam logic [1:0] CTR_STRONG_T  = 2'd3;

   // saturating two-bit counter step toward the resolved outcome
   function automatic logic [1:0] ctr_next(input logic [1:0] cur, input logic taken);
      if (taken)
         return (cur == CTR_STRONG_T) ? cur : cur + 2'd1;
      else
         return (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
   endfunction

endpackage

// File: rtl/bpred_match.sv
module bpred_match #(
   parameter int WAYS  = 16,
   parameter int TAG_W = 26,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]       valid,
   input  logic [WAYS*TAG_W-1:0] tags,
   input  logic [TAG_W-1:0]      probe,
   output logic [WAYS-1:0]       hitv,
   output logic                  hit,
   output logic [WAY_W-1:0]      way
);
   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hitv[w] = valid[w] && (tags[w*TAG_W +: TAG_W] == probe);
   end

   assign hit = |hitv;

   always_comb begin
      way = '0;
      for (int w = 0; w < WAYS; w++)
         if (hitv[w]) way = way | WAY_W'(w);
   end
endmodule

// File: rtl/bpred_lru.sv
module bpred_lru #(
   parameter int WAYS = 16,
   localparam int AGE_W = $clog2(WAYS)
) (
   input  logic [WAYS*AGE_W-1:0] ages_in,
   input  logic [WAYS-1:0]       valid,
   input  logic [AGE_W-1:0]      touch_way,
   output logic [WAYS*AGE_W-1:0] ages_out,
   output logic [AGE_W-1:0]      victim
);
   logic [AGE_W-1:0] touched_age;
   assign touched_age = ages_in[touch_way*AGE_W +: AGE_W];

   for (genvar w = 0; w < WAYS; w++) begin : g_age
      logic [AGE_W-1:0] cur;
      assign cur = ages_in[w*AGE_W +: AGE_W];
      always_comb begin
         if (AGE_W'(w) == touch_way)
            ages_out[w*AGE_W +: AGE_W] = '0;
         else if (cur < touched_age)
            ages_out[w*AGE_W +: AGE_W] = cur + AGE_W'(1);
         else
            ages_out[w*AGE_W +: AGE_W] = cur;
      end
   end

   // first free way wins, otherwise the oldest one
   always_comb begin
      logic found;
      found  = 1'b0;
      victim = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (!found && !valid[w]) begin
            victim = AGE_W'(w);
            found  = 1'b1;
         end
      end
      if (!found)
         for (int w = 0; w < WAYS; w++)
            if (ages_in[w*AGE_W +: AGE_W] == AGE_W'(WAYS-1)) victim = AGE_W'(w);
   end
endmodule

// File: rtl/bpred_pht_step.sv
module bpred_pht_step
   import bpred_pkg::*;
#(
   parameter int HIST_W = 4,
   localparam int PHT_N = 2**HIST_W,
   localparam int PHT_BITS = 2*PHT_N
) (
   input  logic [HIST_W-1:0]   hist_in,
   input  logic [PHT_BITS-1:0] ctrs_in,
   input  logic                taken,
   output logic [HIST_W-1:0]   hist_out,
   output logic [PHT_BITS-1:0] ctrs_out
);
   for (genvar i = 0; i < PHT_N; i++) begin : g_ctr
      assign ctrs_out[2*i +: 2] = (HIST_W'(i) == hist_in)
                                  ? ctr_next(ctrs_in[2*i +: 2], taken)
                                  : ctrs_in[2*i +: 2];
   end

   if (HIST_W == 1) begin : g_hist_one
      assign hist_out = taken;
   end else begin : g_hist_shift
      assign hist_out = {hist_in[HIST_W-2:0], taken};
   end
endmodule

// File: rtl/bpred_local2l.sv
module bpred_local2l
   import bpred_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int SETS     = 16,
   parameter int WAYS     = 16,
   parameter int HIST_W   = 4,
   parameter int LSB_DROP = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_on_exec,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_hit,
   output logic              lk_taken,
   output logic [ADDR_W-1:0] lk_target,
   input  logic              up_valid,
   input  logic [ADDR_W-1:0] up_addr,
   input  logic              up_taken,
   input  logic [ADDR_W-1:0] up_target
);
   localparam int SET_W    = $clog2(SETS);
   localparam int WAY_W    = $clog2(WAYS);
   localparam int TAG_LO   = LSB_DROP + SET_W;
   localparam int TAG_W    = ADDR_W - TAG_LO;
   localparam int PHT_N    = 2**HIST_W;
   localparam int PHT_BITS = 2*PHT_N;
   localparam logic [PHT_BITS-1:0] PHT_INIT = {PHT_N{CTR_WEAK_NT}};

   if (SETS < 2 || (1 << SET_W) != SETS) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
      $error("WAYS must be a power of two, at least 2");
   end
   if (HIST_W < 1 || HIST_W > 8) begin : g_bad_hist
      $error("HIST_W must lie in 1..8");
   end
   if (LSB_DROP < 1 || TAG_W < 1) begin : g_bad_split
      $error("address split leaves no tag or no dropped bits");
   end

   // storage
   logic [SETS-1:0][WAYS-1:0] val_q;
   logic [TAG_W-1:0]    tag_q  [SETS][WAYS];
   logic [ADDR_W-1:0]   tgt_q  [SETS][WAYS];
   logic [HIST_W-1:0]   hist_q [SETS][WAYS];
   logic [PHT_BITS-1:0] pht_q  [SETS][WAYS];
   logic [WAY_W-1:0]    age_q  [SETS][WAYS];

   logic [SET_W-1:0] lk_set, up_set;
   logic [TAG_W-1:0] lk_tag, up_tag;
   logic             unused_lsbs;
   assign lk_set = lk_addr[LSB_DROP +: SET_W];
   assign up_set = up_addr[LSB_DROP +: SET_W];
   assign lk_tag = lk_addr[ADDR_W-1:TAG_LO];
   assign up_tag = up_addr[ADDR_W-1:TAG_LO];
   assign unused_lsbs = ^{lk_addr[LSB_DROP-1:0], up_addr[LSB_DROP-1:0]};

   // per-set views
   logic [WAYS-1:0]       lk_vset, up_vset;
   logic [WAYS*TAG_W-1:0] lk_tags, up_tags;
   logic [WAYS*WAY_W-1:0] lk_ages, up_ages, lk_ages_nx, up_ages_nx;
   assign lk_vset = val_q[lk_set];
   assign up_vset = val_q[up_set];
   for (genvar w = 0; w < WAYS; w++) begin : g_view
      assign lk_tags[w*TAG_W +: TAG_W] = tag_q[lk_set][w];
      assign up_tags[w*TAG_W +: TAG_W] = tag_q[up_set][w];
      assign lk_ages[w*WAY_W +: WAY_W] = age_q[lk_set][w];
      assign up_ages[w*WAY_W +: WAY_W] = age_q[up_set][w];
   end

   logic [WAYS-1:0]  lk_hitv, up_hitv;
   logic             lk_match, up_hit;
   logic [WAY_W-1:0] lk_way, up_way, up_victim, lk_victim_unused, up_slot;

   bpred_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
      .valid(lk_vset), .tags(lk_tags), .probe(lk_tag),
      .hitv(lk_hitv), .hit(lk_match), .way(lk_way));

   bpred_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_up_match (
      .valid(up_vset), .tags(up_tags), .probe(up_tag),
      .hitv(up_hitv), .hit(up_hit), .way(up_way));

   // lookup result, taken from state before this cycle's update
   logic [PHT_BITS-1:0] lk_pht;
   logic [HIST_W-1:0]   lk_hist;
   assign lk_pht    = pht_q[lk_set][lk_way];
   assign lk_hist   = hist_q[lk_set][lk_way];
   assign lk_hit    = lk_valid && lk_match;
   assign lk_taken  = lk_hit && lk_pht[{lk_hist, 1'b1}];
   assign lk_target = lk_hit ? tgt_q[lk_set][lk_way] : '0;

   // update path
   logic up_alloc, up_write, lk_touch;
   assign up_alloc = up_valid && !up_hit && (up_taken || alloc_on_exec);
   assign up_write = up_valid && (up_hit || up_alloc);
   assign up_slot  = up_hit ? up_way : up_victim;
   assign lk_touch = lk_hit && !(up_write && (up_set == lk_set));

   bpred_lru #(.WAYS(WAYS)) u_up_lru (
      .ages_in(up_ages), .valid(up_vset), .touch_way(up_slot),
      .ages_out(up_ages_nx), .victim(up_victim));

   bpred_lru #(.WAYS(WAYS)) u_lk_lru (
      .ages_in(lk_ages), .valid(lk_vset), .touch_way(lk_way),
      .ages_out(lk_ages_nx), .victim(lk_victim_unused));

   logic [HIST_W-1:0]   step_hist_in, step_hist_out;
   logic [PHT_BITS-1:0] step_pht_in, step_pht_out;
   assign step_hist_in = up_hit ? hist_q[up_set][up_way] : '0;
   assign step_pht_in  = up_hit ? pht_q[up_set][up_way]  : PHT_INIT;

   bpred_pht_step #(.HIST_W(HIST_W)) u_step (
      .hist_in(step_hist_in), .ctrs_in(step_pht_in), .taken(up_taken),
      .hist_out(step_hist_out), .ctrs_out(step_pht_out));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val_q <= '0;
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
               age_q[s][w] <= WAY_W'(w);
      end else begin
         if (up_write) begin
            val_q[up_set][up_slot]  <= 1'b1;
            tag_q[up_set][up_slot]  <= up_tag;
            hist_q[up_set][up_slot] <= step_hist_out;
            pht_q[up_set][up_slot]  <= step_pht_out;
            if (up_taken || !up_hit)
               tgt_q[up_set][up_slot] <= up_target;
            for (int w = 0; w < WAYS; w++)
               age_q[up_set][w] <= up_ages_nx[w*WAY_W +: WAY_W];
         end
         if (lk_touch)
            for (int w = 0; w < WAYS; w++)
               age_q[lk_set][w] <= lk_ages_nx[w*WAY_W +: WAY_W];
      end
   end
endmodule

// File: rtl/bpred_local2l_chk.sv
module bpred_local2l_chk #(
   parameter int WAYS   = 16,
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              alloc_on_exec,
   input logic              lk_valid,
   input logic              lk_hit,
   input logic              lk_taken,
   input logic [ADDR_W-1:0] lk_target,
   input logic              up_valid,
   input logic [ADDR_W-1:0] up_addr,
   input logic              up_taken,
   input logic [WAYS-1:0]   lk_hitv,
   input logic [WAYS-1:0]   up_hitv,
   input logic              up_hit
);
   AST_MISS_PREDICTS_NT: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !lk_hit) |-> (!lk_taken && lk_target == '0)); // R3

   AST_LK_SINGLE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_hitv)); // R2

   AST_UP_SINGLE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(up_hitv)); // R2

   AST_ALLOC_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && (up_taken || alloc_on_exec))
      |=> (!(up_valid && up_addr == $past(up_addr)) || up_hit)); // R5

   AST_NT_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && !up_taken && !alloc_on_exec && !up_hit)
      |=> (!(up_valid && up_addr == $past(up_addr)) || !up_hit)); // R4
endmodule

bind bpred_local2l bpred_local2l_chk #(.WAYS(WAYS), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .alloc_on_exec(alloc_on_exec),
   .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_target(lk_target),
   .up_valid(up_valid), .up_addr(up_addr), .up_taken(up_taken),
   .lk_hitv(lk_hitv), .up_hitv(up_hitv), .up_hit(up_hit));

// File: tb/sim_bpred_local2l.sv
`timescale 1ns/1ps
module sim_bpred_local2l;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        alloc_on_exec = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_addr = '0;
   logic        lk_hit, lk_taken;
   logic [31:0] lk_target;
   logic        up_valid = 1'b0;
   logic [31:0] up_addr = '0;
   logic        up_taken = 1'b0;
   logic [31:0] up_target = '0;

   always #10 clk = ~clk;

   bpred_local2l u0 (
      .clk(clk), .rst_n(rst_n), .alloc_on_exec(alloc_on_exec),
      .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit),
      .lk_taken(lk_taken), .lk_target(lk_target),
      .up_valid(up_valid), .up_addr(up_addr), .up_taken(up_taken),
      .up_target(up_target));

   typedef struct {
      logic        hit;
      logic        tk;
      logic [31:0] tgt;
      string       req;
   } exp_t;

   exp_t sb_q[$];
   logic chk_now = 1'b0;
   int   n_cmp = 0;
   int   n_bad = 0;
   logic done = 1'b0;

   // monitor: compare away from the rising edge
   always @(negedge clk) begin
      if (chk_now) begin
         if (sb_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard empty: got hit=%0b tk=%0b tgt=%h expected an item",
                     lk_hit, lk_taken, lk_target);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            n_cmp++;
            if (lk_hit !== e.hit || lk_taken !== e.tk || lk_target !== e.tgt) begin
               n_bad++;
               $display("FAIL %s: got hit=%0b tk=%0b tgt=%h expected hit=%0b tk=%0b tgt=%h",
                        e.req, lk_hit, lk_taken, lk_target, e.hit, e.tk, e.tgt);
            end
         end
      end
   end

   // driver: one cycle of stimulus, optionally pushing an expected lookup result
   task automatic cyc(input logic lv, input logic [31:0] la,
                      input logic uv, input logic [31:0] ua, input logic ut, input logic [31:0] ug,
                      input logic chk, input logic eh, input logic et, input logic [31:0] eg,
                      input string req);
      @(posedge clk); #2;
      lk_valid = lv; lk_addr = la;
      up_valid = uv; up_addr = ua; up_taken = ut; up_target = ug;
      chk_now = chk;
      if (chk) begin
         exp_t e;
         e.hit = eh; e.tk = et; e.tgt = eg; e.req = req;
         sb_q.push_back(e);
      end
   endtask

   task automatic upd(input logic [31:0] a, input logic t, input logic [31:0] g);
      cyc(1'b0, '0, 1'b1, a, t, g, 1'b0, 1'b0, 1'b0, '0, "");
   endtask

   task automatic look(input logic [31:0] a, input logic eh, input logic et,
                       input logic [31:0] eg, input string req);
      cyc(1'b1, a, 1'b0, '0, 1'b0, '0, 1'b1, eh, et, eg, req);
   endtask

   // predict and resolve together every iteration; check the last two periods
   task automatic train(input logic [31:0] a, input logic [7:0] pat, input int len,
                        input string req);
      for (int p = 0; p < 40; p++)
         for (int i = 0; i < len; i++)
            cyc(1'b1, a, 1'b1, a, pat[i], a + 32'h100, p >= 38, 1'b1, pat[i], a + 32'h100, req);
   endtask

   function automatic logic [31:0] way_addr(input logic [31:0] base, input int k);
      return base | (32'(k) << 6);
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1 / R3: empty table
      look(32'h1000, 0, 0, 0, "R1 reset miss");
      look(32'h2004, 0, 0, 0, "R3 miss predicts not taken");

      // R4: allocate only on taken
      upd(32'h1000, 1'b0, 32'hA0);
      look(32'h1000, 0, 0, 0, "R4 not-taken miss leaves no entry");
      upd(32'h1000, 1'b1, 32'hA0);
      look(32'h1000, 1, 0, 32'hA0, "R6 fresh entry weak not taken, target stored");
      upd(32'h1000, 1'b0, 32'hBB);
      upd(32'h1000, 1'b0, 32'hBB);
      upd(32'h1000, 1'b0, 32'hBB);
      look(32'h1000, 1, 0, 32'hA0, "R4 entry kept after not-taken updates");

      // R5: allocate on execution; R7 saturation at 0
      alloc_on_exec = 1'b1;
      upd(32'h2004, 1'b0, 32'hB0);
      look(32'h2004, 1, 0, 32'hB0, "R5 not-taken miss allocates");
      upd(32'h2004, 1'b0, 32'hB1);
      look(32'h2004, 1, 0, 32'hB0, "R7 counter holds at 0");
      alloc_on_exec = 1'b0;

      // R7: counter stepping, history shift, target refresh
      for (int i = 0; i < 4; i++) upd(32'h400C, 1'b1, 32'h111);
      look(32'h400C, 1, 0, 32'h111, "R7 history 1111 counter 1");
      upd(32'h400C, 1'b1, 32'h111);
      look(32'h400C, 1, 1, 32'h111, "R7 counter 2 predicts taken");
      for (int i = 0; i < 3; i++) upd(32'h400C, 1'b1, 32'h111);
      look(32'h400C, 1, 1, 32'h111, "R7 counter holds at 3");
      upd(32'h400C, 1'b0, 32'h999);
      look(32'h400C, 1, 0, 32'h111, "R7 history shifted to 1110");
      upd(32'h400C, 1'b1, 32'h222);
      look(32'h400C, 1, 0, 32'h222, "R7 taken update replaces target");

      // R2: index and tag split
      upd(32'h5010, 1'b1, 32'h55);
      look(32'h5011, 1, 0, 32'h55, "R2 low bits ignored");
      look(32'h5013, 1, 0, 32'h55, "R2 low bits ignored");
      look(32'h5050, 0, 0, 0, "R2 bit 6 differs");
      look(32'h80005010, 0, 0, 0, "R2 bit 31 differs");

      // R8: pattern learning
      train(32'h6018, 8'b0000_1111, 5, "R8 pattern TTTTN");
      train(32'h701C, 8'b0000_0011, 4, "R8 pattern TTNN");
      train(32'h8020, 8'b0000_1111, 8, "R8 pattern TTTTNNNN");

      // R9: LRU eviction in set 5
      for (int k = 0; k < 16; k++) upd(way_addr(32'h14, k), 1'b1, 32'h500 + 32'(k));
      look(way_addr(32'h14, 0), 1, 0, 32'h500, "R9 refresh way 0");
      upd(way_addr(32'h14, 16), 1'b1, 32'h510);
      look(way_addr(32'h14, 1), 0, 0, 0, "R9 oldest entry evicted");
      look(way_addr(32'h14, 16), 1, 0, 32'h510, "R9 new entry present");
      look(way_addr(32'h14, 0), 1, 0, 32'h500, "R9 refreshed entry kept");
      look(way_addr(32'h14, 2), 1, 0, 32'h502, "R9 other entry kept");

      // R10: same-cycle lookup and update of one branch
      for (int i = 0; i < 5; i++) upd(32'h9028, 1'b1, 32'h90);
      cyc(1'b1, 32'h9028, 1'b1, 32'h9028, 1'b0, 32'h0, 1'b1, 1, 1, 32'h90,
          "R10 lookup sees pre-update counter");
      look(32'h9028, 1, 0, 32'h90, "R10 next lookup sees new history");

      // R10: same-set lookup and update, update recency wins
      for (int k = 0; k < 16; k++) upd(way_addr(32'h24, k), 1'b1, 32'h900 + 32'(k));
      cyc(1'b1, way_addr(32'h24, 0), 1'b1, way_addr(32'h24, 1), 1'b1, 32'h901,
          1'b1, 1, 0, 32'h900, "R10 same-set lookup hit");
      upd(way_addr(32'h24, 16), 1'b1, 32'h910);
      look(way_addr(32'h24, 0), 0, 0, 0, "R10 lookup touch dropped, way 0 evicted");
      look(way_addr(32'h24, 1), 1, 0, 32'h901, "R10 update touch kept way 1");
      look(way_addr(32'h24, 16), 1, 0, 32'h910, "R10 new entry present");

      cyc(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, 0, 0, 0, "");
      @(posedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got no completion expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule